// File: doc/BRIEF.md
# High-Speed Entry Sequencer for a Serial Display Lane Pair

This block sequences one data lane and one clock lane of a low-power/high-speed differential serial link on the transmit side. Both lanes run in the byte-clock domain. The block drives the single-ended line states on each lane and the enable of the high-speed driver. Each state lasts for a whole number of byte-clock cycles, and that number comes from a field of one of three timing words.

After reset the clock lane makes its single transition into continuous high-speed mode. From then on the data lane serves burst requests. Each burst walks the line through the low-power start states, a run of zero bytes and a sync byte, then carries the payload. It closes with a trail state and a low-power exit gap. The sequencer always runs every programmed state to its full length, so a waiting request can never shorten or skip the low-power start states.

Top module: `hs_lane_sequencer`

## Requirements
- R1: While reset is held, both lanes show the stop state 2'b11 (bit 1 is the positive wire, bit 0 the negative), both high-speed enables are low, `hsByte` is 0 and `txReady` is high.
- R2: Once after reset the clock lane runs through 2'b01 for len(lpx) cycles and then 2'b00 for len(clkPrep) cycles. It then raises `clkHsEn`, which stays high until the next reset.
- R3: The data lane leaves 2'b11 only after `clkHsEn` has been high for len(clkZero)+1 cycles.
- R4: A `burstReq` seen while `txReady` is high starts 2'b01 on the data lane in the next cycle, and `txReady` is low from that cycle on. A request seen while the clock lane is still starting is held until the clock lane is ready.
- R5: Every burst holds the data lane at 2'b01 for len(lpx) cycles and then at 2'b00 for len(hsPrep) cycles before `datHsEn` rises.
- R6: After the prepare state, `datHsEn` is high with `hsByte` = 0x00 for len(hsZero) cycles, followed by one cycle with `hsByte` = 0xB8.
- R7: `txValid` is sampled in the sync cycle and in every payload cycle. While it is high, the `txByte` sampled appears on `hsByte` in the next cycle. The first cycle in which it is sampled low ends the payload.
- R8: The trail state keeps `datHsEn` high for len(hsTrail) cycles. During it `hsByte` is 0xFF when bit 7 (sent last) of the last byte sent is 0, and 0x00 when that bit is 1. The sync byte counts as the last byte when the payload is empty.
- R9: After the trail, the data lane shows 2'b11 with `txReady` low for len(hsExit) cycles, and then `txReady` returns high.
- R10: Field positions: word 0 holds lpx [15:8] and hsExit [7:0]; word 1 holds clkPrep [31:24] and clkZero [23:16]; word 2 holds hsPrep [23:16], hsZero [15:8] and hsTrail [7:0]. len(f) is f, or 1 when f is 0.
- R11: The timing words are sampled at the clock edge where the data lane leaves idle. Changes made later do not affect the burst in progress.
- R12: A `burstReq` seen while `txReady` is low has no effect. Once the burst ends, the lane stays in 2'b11 with `txReady` high.
- R13: While `datHsEn` is high, the data lane line pair reads 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Active-low synchronous reset |
| burstReq | input | 1 | Request for a high-speed burst |
| txValid | input | 1 | Payload byte valid |
| txByte | input | 8 | Payload byte |
| timReg0 | input | 32 | Timing word 0 |
| timReg1 | input | 32 | Timing word 1 |
| timReg2 | input | 32 | Timing word 2 |
| clkLp | output | 2 | Clock lane low-power line pair |
| clkHsEn | output | 1 | Clock lane high-speed driver enable |
| datLp | output | 2 | Data lane low-power line pair |
| datHsEn | output | 1 | Data lane high-speed driver enable |
| hsByte | output | 8 | Byte handed to the data lane serializer |
| txReady | output | 1 | Sequencer idle and able to accept a burst |

## Verification
The hardest case to reach from the ports is a request that arrives before the clock lane has finished its own entry. The bench raises `burstReq` during reset and keeps it high across reset release. This makes the request wait through the whole clock-lane start, and the bench then counts the cycles in which the clock lane is high-speed while the data lane is still stopped. A second hard case is a change of the timing words in the middle of a burst, combined with a stray request. The bench rewrites all three words during the first low-power state and pulses `burstReq`. It then checks that the burst keeps its old timing, that the next burst takes the new all-zero words as one-cycle states, and that the stray request never starts a burst.

// File: rtl/hs_seq_pkg.sv
`timescale 1ns/1ps
package hs_seq_pkg;
  localparam int FIELD_W = 8;
  localparam int WORD_W  = 32;

  localparam logic [1:0] LP_STOP = 2'b11;
  localparam logic [1:0] LP_REQ  = 2'b01;
  localparam logic [1:0] LP_BRG  = 2'b00;

  typedef struct packed {
    logic [FIELD_W-1:0] lpx;
    logic [FIELD_W-1:0] hsExit;
    logic [FIELD_W-1:0] clkPrep;
    logic [FIELD_W-1:0] clkZero;
    logic [FIELD_W-1:0] hsPrep;
    logic [FIELD_W-1:0] hsZero;
    logic [FIELD_W-1:0] hsTrail;
  } timing_t;

  typedef enum logic [2:0] {
    F_LPX, F_HSEXIT, F_CLKPREP, F_CLKZERO, F_HSPREP, F_HSZERO, F_HSTRAIL
  } fieldSel_e;

  typedef enum logic [1:0] {OUT_OFF, OUT_ZERO, OUT_DATA, OUT_TRAIL} outSel_e;

  typedef enum logic [2:0] {
    D_IDLE, D_LPX, D_PREP, D_ZERO, D_SYNC, D_PAY, D_TRAIL, D_EXIT
  } datState_e;

  typedef enum logic [2:0] {C_INIT, C_LPX, C_PREP, C_ZERO, C_HS} clkState_e;

  typedef struct packed {
    logic      dLoad;
    fieldSel_e dSel;
    logic      cLoad;
    fieldSel_e cSel;
    logic      syncLoad;
    logic      capByte;
    outSel_e   outSel;
    logic      freeze;
  } seqStrobe_t;
endpackage

// File: rtl/hs_seq_dpath.sv
`timescale 1ns/1ps
module hs_seq_dpath
  import hs_seq_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] SYNC_BYTE = 8'hB8
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          stb,
  input  logic [WORD_W-1:0]   timReg0,
  input  logic [WORD_W-1:0]   timReg1,
  input  logic [WORD_W-1:0]   timReg2,
  input  logic [BYTE_W-1:0]   txByte,
  output logic                dDone,
  output logic                cDone,
  output logic [BYTE_W-1:0]   hsByte
);
  localparam int N_CNT = 2;

  timing_t liveTim, shadowTim, effTim;
  logic [BYTE_W-1:0] payReg;
  logic [N_CNT-1:0] ldVec;
  logic [N_CNT-1:0] doneVec;
  fieldSel_e selVec [N_CNT];
  logic unusedBits;

  assign liveTim.lpx     = timReg0[15:8];
  assign liveTim.hsExit  = timReg0[7:0];
  assign liveTim.clkPrep = timReg1[31:24];
  assign liveTim.clkZero = timReg1[23:16];
  assign liveTim.hsPrep  = timReg2[23:16];
  assign liveTim.hsZero  = timReg2[15:8];
  assign liveTim.hsTrail = timReg2[7:0];
  assign unusedBits = ^{timReg0[31:16], timReg1[15:0], timReg2[31:24]};

  // Timing words follow the live inputs while the data lane is idle and
  // are frozen from the edge that leaves idle.
  always_ff @(posedge clk) begin
    if (!rstN) shadowTim <= '0;
    else if (!stb.freeze) shadowTim <= liveTim;
  end
  assign effTim = stb.freeze ? shadowTim : liveTim;

  function automatic logic [FIELD_W-1:0] pickLen(fieldSel_e s, timing_t t);
    logic [FIELD_W-1:0] raw;
    case (s)
      F_LPX:     raw = t.lpx;
      F_HSEXIT:  raw = t.hsExit;
      F_CLKPREP: raw = t.clkPrep;
      F_CLKZERO: raw = t.clkZero;
      F_HSPREP:  raw = t.hsPrep;
      F_HSZERO:  raw = t.hsZero;
      default:   raw = t.hsTrail;
    endcase
    return (raw == '0) ? FIELD_W'(1) : raw;
  endfunction

  assign ldVec     = {stb.cLoad, stb.dLoad};
  assign selVec[0] = stb.dSel;
  assign selVec[1] = stb.cSel;

  for (genvar g = 0; g < N_CNT; g++) begin : gCnt
    logic [FIELD_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rstN) cnt <= '0;
      else if (ldVec[g]) cnt <= pickLen(selVec[g], effTim) - FIELD_W'(1);
      else if (cnt != '0) cnt <= cnt - FIELD_W'(1);
    end
    assign doneVec[g] = (cnt == '0);
  end

  assign dDone = doneVec[0];
  assign cDone = doneVec[1];

  always_ff @(posedge clk) begin
    if (!rstN) payReg <= '0;
    else if (stb.syncLoad) payReg <= SYNC_BYTE;
    else if (stb.capByte) payReg <= txByte;
  end

  always_comb begin
    case (stb.outSel)
      OUT_DATA:  hsByte = payReg;
      OUT_TRAIL: hsByte = {BYTE_W{~payReg[BYTE_W-1]}};
      default:   hsByte = '0;
    endcase
  end

  // R8
  trail_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.outSel == OUT_TRAIL && $past(stb.outSel) == OUT_TRAIL) |-> $stable(hsByte));
endmodule

// File: rtl/hs_seq_ctrl.sv
`timescale 1ns/1ps
module hs_seq_ctrl
  import hs_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       burstReq,
  input  logic       txValid,
  input  logic       dDone,
  input  logic       cDone,
  output seqStrobe_t stb,
  output logic [1:0] clkLp,
  output logic       clkHsEn,
  output logic [1:0] datLp,
  output logic       datHsEn,
  output logic       txReady
);
  datState_e dState, dNext;
  clkState_e cState, cNext;
  logic pend, pendNext, clkUp, startBurst;

  assign clkUp      = (cState == C_HS);
  assign txReady    = (dState == D_IDLE) && !pend;
  assign startBurst = (dState == D_IDLE) && clkUp && (pend || burstReq);

  always_comb begin
    pendNext = pend;
    if (startBurst) pendNext = 1'b0;
    else if (dState == D_IDLE && burstReq) pendNext = 1'b1;
  end

  always_comb begin
    stb        = '0;
    stb.dSel   = F_LPX;
    stb.cSel   = F_LPX;
    stb.outSel = OUT_OFF;
    stb.freeze = (dState != D_IDLE);
    dNext      = dState;
    cNext      = cState;

    case (cState)
      C_INIT: begin
        cNext = C_LPX;
        stb.cLoad = 1'b1;
        stb.cSel  = F_LPX;
      end
      C_LPX: if (cDone) begin
        cNext = C_PREP;
        stb.cLoad = 1'b1;
        stb.cSel  = F_CLKPREP;
      end
      C_PREP: if (cDone) begin
        cNext = C_ZERO;
        stb.cLoad = 1'b1;
        stb.cSel  = F_CLKZERO;
      end
      C_ZERO: if (cDone) cNext = C_HS;
      default: cNext = C_HS;
    endcase

    case (dState)
      D_IDLE: if (startBurst) begin
        dNext = D_LPX;
        stb.dLoad = 1'b1;
        stb.dSel  = F_LPX;
      end
      D_LPX: if (dDone) begin
        dNext = D_PREP;
        stb.dLoad = 1'b1;
        stb.dSel  = F_HSPREP;
      end
      D_PREP: if (dDone) begin
        dNext = D_ZERO;
        stb.dLoad = 1'b1;
        stb.dSel  = F_HSZERO;
      end
      D_ZERO: begin
        stb.outSel = OUT_ZERO;
        if (dDone) begin
          dNext = D_SYNC;
          stb.syncLoad = 1'b1;
        end
      end
      D_SYNC, D_PAY: begin
        stb.outSel = OUT_DATA;
        if (txValid) begin
          dNext = D_PAY;
          stb.capByte = 1'b1;
        end else begin
          dNext = D_TRAIL;
          stb.dLoad = 1'b1;
          stb.dSel  = F_HSTRAIL;
        end
      end
      D_TRAIL: begin
        stb.outSel = OUT_TRAIL;
        if (dDone) begin
          dNext = D_EXIT;
          stb.dLoad = 1'b1;
          stb.dSel  = F_HSEXIT;
        end
      end
      default: if (dDone) dNext = D_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dState <= D_IDLE;
      cState <= C_INIT;
      pend   <= 1'b0;
    end else begin
      dState <= dNext;
      cState <= cNext;
      pend   <= pendNext;
    end
  end

  always_comb begin
    clkLp   = LP_STOP;
    clkHsEn = 1'b0;
    case (cState)
      C_LPX:  clkLp = LP_REQ;
      C_PREP: clkLp = LP_BRG;
      C_ZERO, C_HS: begin
        clkLp   = LP_BRG;
        clkHsEn = 1'b1;
      end
      default: clkLp = LP_STOP;
    endcase
  end

  always_comb begin
    datLp   = LP_STOP;
    datHsEn = 1'b0;
    case (dState)
      D_LPX:  datLp = LP_REQ;
      D_PREP: datLp = LP_BRG;
      D_ZERO, D_SYNC, D_PAY, D_TRAIL: begin
        datLp   = LP_BRG;
        datHsEn = 1'b1;
      end
      default: datLp = LP_STOP;
    endcase
  end

  // R5
  hs_after_bridge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(datHsEn) |-> ($past(datLp) == LP_BRG));
  // R5
  bridge_after_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (datLp == LP_BRG && !datHsEn) |-> ($past(datLp) != LP_STOP));
  // R3
  data_needs_clock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (datLp != LP_STOP) |-> clkHsEn);
  // R9
  ready_stopped_chk: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> (datLp == LP_STOP && !datHsEn));
  // R2
  clock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(clkHsEn) |-> clkHsEn);
endmodule

// File: rtl/hs_lane_sequencer.sv
`timescale 1ns/1ps
module hs_lane_sequencer
  import hs_seq_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] SYNC_BYTE = 8'hB8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              burstReq,
  input  logic              txValid,
  input  logic [BYTE_W-1:0] txByte,
  input  logic [31:0]       timReg0,
  input  logic [31:0]       timReg1,
  input  logic [31:0]       timReg2,
  output logic [1:0]        clkLp,
  output logic              clkHsEn,
  output logic [1:0]        datLp,
  output logic              datHsEn,
  output logic [BYTE_W-1:0] hsByte,
  output logic              txReady
);
  seqStrobe_t stb;
  logic dDone, cDone;

  hs_seq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .burstReq(burstReq), .txValid(txValid),
    .dDone(dDone), .cDone(cDone), .stb(stb),
    .clkLp(clkLp), .clkHsEn(clkHsEn), .datLp(datLp), .datHsEn(datHsEn),
    .txReady(txReady)
  );

  hs_seq_dpath #(.BYTE_W(BYTE_W), .SYNC_BYTE(SYNC_BYTE)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .timReg0(timReg0), .timReg1(timReg1), .timReg2(timReg2),
    .txByte(txByte), .dDone(dDone), .cDone(cDone), .hsByte(hsByte)
  );

  // R13
  hs_bridge_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    datHsEn |-> (datLp == LP_BRG));
endmodule

// File: tb/hs_lane_sequencer_test.sv
`timescale 1ns/1ps
module hs_lane_sequencer_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, burstReq, txValid;
  logic [7:0] txByte;
  logic [31:0] timReg0, timReg1, timReg2;
  logic [1:0] clkLp, datLp;
  logic clkHsEn, datHsEn, txReady;
  logic [7:0] hsByte;

  hs_lane_sequencer uut (
    .clk(clk), .rstN(rstN), .burstReq(burstReq), .txValid(txValid),
    .txByte(txByte), .timReg0(timReg0), .timReg1(timReg1), .timReg2(timReg2),
    .clkLp(clkLp), .clkHsEn(clkHsEn), .datLp(datLp), .datHsEn(datHsEn),
    .hsByte(hsByte), .txReady(txReady)
  );

  int checks = 0;
  int errors = 0;

  int nClk01, nClk00, nGap, n01, n00, nZero, nTrail, nExit, payIdx;
  int payBad, trailBad, pairBad, startCyc, readyAt0;
  bit seenSync;
  logic [31:0] swap0, swap1, swap2;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int flen(input logic [7:0] f);
    return (f == 8'd0) ? 1 : int'(f);
  endfunction

  task automatic observe(input int nBytes, input logic [63:0] pay,
                         input logic [7:0] expTrail, input bit swap, input bit poke);
    int phase;
    phase = 0;
    nClk01 = 0; nClk00 = 0; nGap = 0; n01 = 0; n00 = 0; nZero = 0;
    nTrail = 0; nExit = 0; payIdx = 0; payBad = 0; trailBad = 0;
    pairBad = 0; startCyc = -1; readyAt0 = -1; seenSync = 0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      if (cyc == 0) begin
        readyAt0 = int'(txReady);
        burstReq = 1'b0;
      end
      if (!clkHsEn) begin
        if (clkLp == 2'b01) nClk01++;
        else if (clkLp == 2'b00) nClk00++;
      end
      if (phase == 0) begin
        if (datLp == 2'b01 && !datHsEn) begin
          phase = 1;
          startCyc = cyc;
        end else if (clkHsEn) nGap++;
      end
      if (phase == 1) begin
        if (!datHsEn && datLp == 2'b01) n01++;
        else if (!datHsEn && datLp == 2'b00) n00++;
        else if (datHsEn) begin
          if (datLp != 2'b00) pairBad++;
          if (!seenSync) begin
            if (hsByte == 8'h00) nZero++;
            else if (hsByte == 8'hB8) seenSync = 1;
            else payBad++;
          end else if (payIdx < nBytes) begin
            if (hsByte != pay[8*payIdx +: 8]) payBad++;
            payIdx++;
          end else begin
            nTrail++;
            if (hsByte != expTrail) trailBad++;
          end
        end else if (datLp == 2'b11) begin
          if (txReady) break;
          nExit++;
        end else pairBad++;
      end
      if (datHsEn && seenSync && payIdx < nBytes) begin
        txValid = 1'b1;
        txByte  = pay[8*payIdx +: 8];
      end else begin
        txValid = 1'b0;
        txByte  = 8'h00;
      end
      if (swap && cyc == 2) begin
        timReg0 = swap0; timReg1 = swap1; timReg2 = swap2;
      end
      if (poke && cyc == 4) burstReq = 1'b1;
      if (poke && cyc == 5) burstReq = 1'b0;
    end
  endtask

  task automatic runBurst(input logic [31:0] r0, r1, r2, input int nBytes,
                          input logic [63:0] pay, input bit startup,
                          input bit swap, input bit poke);
    logic lastBit;
    logic [7:0] expTrail;
    lastBit  = (nBytes == 0) ? 1'b1 : pay[8*(nBytes-1)+7];
    expTrail = lastBit ? 8'h00 : 8'hFF;
    if (!startup) begin
      timReg0 = r0; timReg1 = r1; timReg2 = r2;
      @(negedge clk);
      while (!txReady) @(negedge clk);
      burstReq = 1'b1;
    end
    observe(nBytes, pay, expTrail, swap, poke);
    if (startup) begin
      check(nClk01 == flen(r0[15:8]), "R2", "clock lane LP01 cycles", nClk01, flen(r0[15:8]));
      check(nClk00 == flen(r1[31:24]), "R2", "clock lane LP00 cycles", nClk00, flen(r1[31:24]));
      check(nGap == flen(r1[23:16]) + 1, "R3", "clock HS cycles before data start", nGap, flen(r1[23:16]) + 1);
    end else begin
      check(startCyc == 0, "R4", "cycle of first LP01 after request", startCyc, 0);
    end
    check(readyAt0 == 0, "R4", "ready after request", readyAt0, 0);
    check(n01 == flen(r0[15:8]), "R5", "data LP01 cycles", n01, flen(r0[15:8]));
    check(n00 == flen(r2[23:16]), "R5", "data LP00 cycles", n00, flen(r2[23:16]));
    check(nZero == flen(r2[15:8]), "R6", "HS zero cycles", nZero, flen(r2[15:8]));
    check(seenSync, "R6", "sync byte seen", int'(seenSync), 1);
    check(payIdx == nBytes && payBad == 0, "R7", "payload bytes matched", payIdx - payBad, nBytes);
    check(nTrail == flen(r2[7:0]), "R8", "trail cycles", nTrail, flen(r2[7:0]));
    check(trailBad == 0, "R8", "trail byte mismatches", trailBad, 0);
    check(nExit == flen(r0[7:0]), "R9", "exit cycles with ready low", nExit, flen(r0[7:0]));
    check(pairBad == 0, "R13", "bad line pair cycles", pairBad, 0);
    check(clkHsEn == 1'b1, "R2", "clock lane still HS", int'(clkHsEn), 1);
  endtask

  task automatic testReset();
    rstN = 1'b0; burstReq = 1'b1; txValid = 1'b0; txByte = 8'h00;
    timReg0 = 32'h0000_0306; timReg1 = 32'h030f_0a04; timReg2 = 32'h0003_0706;
    repeat (3) @(negedge clk);
    check(clkLp == 2'b11, "R1", "clock pair in reset", int'(clkLp), 3);
    check(datLp == 2'b11, "R1", "data pair in reset", int'(datLp), 3);
    check(!clkHsEn && !datHsEn, "R1", "HS enables in reset", int'({clkHsEn, datHsEn}), 0);
    check(hsByte == 8'h00, "R1", "hsByte in reset", int'(hsByte), 0);
    check(txReady == 1'b1, "R1", "ready in reset", int'(txReady), 1);
    rstN = 1'b1;
  endtask

  task automatic testStartup();
    // request held from reset: waits for clock lane (R3, R4)
    runBurst(32'h0000_0306, 32'h030f_0a04, 32'h0003_0706, 0, 64'h0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic testPayload();
    // last bit 0 -> trail all ones (R7, R8)
    runBurst(32'h0000_0306, 32'h030f_0a04, 32'h0003_0706, 4,
             64'h0000_0000_35C3_9A12, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testFreezeAndIgnore();
    int bad;
    swap0 = 32'h0; swap1 = 32'h0; swap2 = 32'h0;
    runBurst(32'h0000_0502, 32'h030f_0a04, 32'h0004_0209, 3,
             64'h0000_0000_0080_7F01, 1'b0, 1'b1, 1'b1);
    // R11: old words kept after mid-burst rewrite
    check(n01 == 5, "R11", "LP01 cycles after word rewrite", n01, 5);
    check(nExit == 2, "R11", "exit cycles after word rewrite", nExit, 2);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (datLp != 2'b11 || !txReady || datHsEn) bad++;
    end
    // R12: stray request started nothing
    check(bad == 0, "R12", "idle cycles disturbed after stray request", bad, 0);
  endtask

  task automatic testZeroFields();
    runBurst(32'h0, 32'h0, 32'h0, 2, 64'h0000_0000_0000_00B8, 1'b0, 1'b0, 1'b0);
    // R10: zero fields count as one cycle
    check(n01 == 1 && n00 == 1, "R10", "LP01+LP00 cycles with zero fields", n01 + n00, 2);
    check(nZero == 1 && nTrail == 1 && nExit == 1, "R10", "zero/trail/exit cycles", nZero + nTrail + nExit, 3);
  endtask

  task automatic testSingleByte();
    runBurst(32'h0000_0306, 32'h030f_0a04, 32'h0003_0706, 1,
             64'h0000_0000_0000_00FF, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL R1 watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testStartup();
    testPayload();
    testFreezeAndIgnore();
    testZeroFields();
    testSingleByte();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule